// File: doc/BRIEF.md
# SECAM FM Chroma Subcarrier Generator

This block builds the frequency-modulated colour subcarrier of a SECAM composite signal from band-limited, pre-emphasized colour-difference samples, and adds it to a luma sample that already carries sync and blanking. The two colour-difference channels take turns by video line. Each line uses its own centre frequency and its own deviation per unit of colour. The instantaneous frequency is the centre plus the deviation scaled by the current colour sample, so the carrier phase is the running integral of the colour signal.

The modulation runs at baseband. One phase accumulator integrates the offset of the line's centre frequency from a fixed 4.286 MHz reference, plus the colour-scaled deviation. A second accumulator runs the reference itself. The subcarrier is then the angle-sum product: cos(reference)·sin(baseband) + sin(reference)·cos(baseband). That product is scaled by a gain, added to the luma and clipped to the output range. When the output standard is not SECAM, the enable is low, all internal state freezes and luma passes straight through. The sample clock is 27 MHz.

Top module: `secam_fm_gen`

## Requirements
- R1: While rst_ni is low, cvbs_o is 0. The phase accumulators and the channel select also clear: the channel select clears to the blue channel, and the two accumulators clear to phase 0.
- R2: The channel select takes effect only while en_i is 1. On a cycle with frame_i = 1 it becomes the blue channel (db_i). Otherwise it flips on every cycle with line_i = 1. frame_i wins when both strobes are high. The active line's sample is blue on even lines after a frame strobe and red (dr_i) on odd lines.
- R3: While en_i is 1, the reference phase advances every cycle by round(4.286e6·2^32/27e6) modulo 2^32.
- R4: While en_i and active_i are both 1, the baseband phase advances by round((fc−4.286e6)·2^32/27e6) + c·round(fd·2^24/27e6) modulo 2^32. For the blue channel fc = 4.25 MHz and fd = 230 kHz. For the red channel fc = 4.40625 MHz and fd = 280 kHz. Here c is the selected signed 10-bit colour sample, in which one unit equals 256 LSBs. While active_i is 0, the baseband phase holds.
- R5: Each phase uses its top 10 bits as angle a. The sine is s(a) = h·(512−h)/512, where h = a mod 512 and the division truncates, and it is negated when a ≥ 512 (range ±128). The cosine is s(a+256 mod 1024).
- R6: On an enabled, active cycle, cvbs_o on the next cycle equals ysync_i + floor(gain_i·(cos(ref)·sin(bb) + sin(ref)·cos(bb)) / 2^15). All values are taken in the same cycle, and the phases are taken before that cycle's update.
- R7: On an enabled cycle with active_i = 0, cvbs_o on the next cycle equals ysync_i.
- R8: On a cycle with en_i = 0, cvbs_o on the next cycle equals ysync_i, and no phase or channel state changes.
- R9: The sum of R6 is clipped to the range 0 to 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1 when the output standard is SECAM |
| frame_i | input | 1 | Frame start strobe |
| line_i | input | 1 | Line start strobe |
| active_i | input | 1 | Active video window |
| db_i | input | 10 | Pre-emphasized blue colour difference, signed, 256 LSB per unit |
| dr_i | input | 10 | Pre-emphasized red colour difference, signed, 256 LSB per unit |
| gain_i | input | 8 | Unsigned subcarrier gain |
| ysync_i | input | 10 | Luma with sync and blanking, unsigned |
| cvbs_o | output | 10 | Registered composite sample |

## Verification
The assertions take the line and frame strobes as arriving only when active_i is low. They also take en_i as a mode level that changes only between lines, so a strobe never meets a disable cycle in mid-line. The stimulus keeps to this. Every generated line is a strobe cycle followed by blanking, then an active run, and the disabled stretch begins and ends on line boundaries. Inside the disabled stretch, strobes, colour and gain are driven at random to show that they leave no trace once the block is enabled again.

// File: rtl/secam_fm_pkg.sv
package secam_fm_pkg;

  typedef enum logic {CH_DB = 1'b0, CH_DR = 1'b1} chan_e;

  // frequency in Hz to accumulator increment, scaled by 2^(ph_w-frac)/fs, rounded
  function automatic longint hz_to_inc(input longint hz, input longint fs,
                                       input int ph_w, input int frac);
    longint num;
    num = (hz < 0 ? -hz : hz) <<< (ph_w - frac);
    num = (num + fs / 2) / fs;
    return (hz < 0) ? -num : num;
  endfunction

endpackage

// File: rtl/secam_line_sel.sv
module secam_line_sel
  import secam_fm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  frame_i,
  input  logic  line_i,
  output chan_e chan_o
);

  chan_e chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= CH_DB;
    end else if (en_i) begin
      if (frame_i)     chan_q <= CH_DB;
      else if (line_i) chan_q <= (chan_q == CH_DB) ? CH_DR : CH_DB;
    end
  end

  assign chan_o = chan_q;

endmodule

// File: rtl/secam_phase_acc.sv
module secam_phase_acc #(
  parameter int PH_W  = 32,
  parameter int ANG_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic signed [PH_W-1:0] inc_i,
  output logic [ANG_W-1:0]       ang_o
);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (step_i) ph_q <= ph_q + inc_i;
  end

  assign ang_o = ph_q[PH_W-1 -: ANG_W];

endmodule

// File: rtl/secam_sine.sv
module secam_sine #(
  parameter int ANG_W = 10,
  localparam int SIN_W = ANG_W - 1
) (
  input  logic [ANG_W-1:0]        ang_i,
  output logic signed [SIN_W-1:0] sin_o,
  output logic signed [SIN_W-1:0] cos_o
);

  localparam int H_W = ANG_W - 1;
  localparam int M_W = 2 * ANG_W;
  localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);
  localparam logic [ANG_W-1:0] HALF    = ANG_W'(1) << H_W;

  logic [ANG_W-1:0] ang_c;
  logic [M_W-1:0]   m_s, m_c;
  logic [SIN_W-1:0] mag_s, mag_c;

  assign ang_c = ang_i + QUARTER;

  // parabolic half-wave: h*(HALF-h)/HALF, sign from the top angle bit
  always_comb begin
    m_s   = M_W'(ang_i[H_W-1:0]) * M_W'(HALF - {1'b0, ang_i[H_W-1:0]});
    m_c   = M_W'(ang_c[H_W-1:0]) * M_W'(HALF - {1'b0, ang_c[H_W-1:0]});
    mag_s = SIN_W'(m_s >> H_W);
    mag_c = SIN_W'(m_c >> H_W);
    sin_o = ang_i[ANG_W-1] ? -$signed(mag_s) : $signed(mag_s);
    cos_o = ang_c[ANG_W-1] ? -$signed(mag_c) : $signed(mag_c);
  end

endmodule

// File: rtl/secam_fm_gen.sv
module secam_fm_gen
  import secam_fm_pkg::*;
#(
  parameter int FS_HZ     = 27_000_000,
  parameter int REF_HZ    = 4_286_000,
  parameter int DB_CTR_HZ = 4_250_000,
  parameter int DR_CTR_HZ = 4_406_250,
  parameter int DB_DEV_HZ = 230_000,
  parameter int DR_DEV_HZ = 280_000,
  parameter int PH_W      = 32,
  parameter int ANG_W     = 10,
  parameter int C_W       = 10,
  parameter int C_FRAC    = 8,
  parameter int G_W       = 8,
  parameter int Y_W       = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           frame_i,
  input  logic           line_i,
  input  logic           active_i,
  input  logic [C_W-1:0] db_i,
  input  logic [C_W-1:0] dr_i,
  input  logic [G_W-1:0] gain_i,
  input  logic [Y_W-1:0] ysync_i,
  output logic [Y_W-1:0] cvbs_o
);

  localparam int SIN_W = ANG_W - 1;
  localparam int MIX_W = 2 * SIN_W + 1;
  localparam int SCL_W = MIX_W + G_W + 1;
  localparam int SHIFT = 2 * (ANG_W - 3) + 1;
  localparam logic signed [PH_W-1:0] REF_INC =
    PH_W'(hz_to_inc(REF_HZ, FS_HZ, PH_W, 0));
  localparam logic signed [PH_W-1:0] DB_OFF =
    PH_W'(hz_to_inc(DB_CTR_HZ - REF_HZ, FS_HZ, PH_W, 0));
  localparam logic signed [PH_W-1:0] DR_OFF =
    PH_W'(hz_to_inc(DR_CTR_HZ - REF_HZ, FS_HZ, PH_W, 0));
  localparam logic signed [PH_W-1:0] DB_DEV =
    PH_W'(hz_to_inc(DB_DEV_HZ, FS_HZ, PH_W, C_FRAC));
  localparam logic signed [PH_W-1:0] DR_DEV =
    PH_W'(hz_to_inc(DR_DEV_HZ, FS_HZ, PH_W, C_FRAC));
  localparam logic signed [SCL_W-1:0] Y_MAX = SCL_W'((1 << Y_W) - 1);

  chan_e chan;
  logic  chan_dr;

  secam_line_sel u_line_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .frame_i(frame_i),
    .line_i (line_i),
    .chan_o (chan)
  );

  assign chan_dr = (chan == CH_DR);

  // baseband increment: per-line offset plus deviation times colour
  logic signed [C_W-1:0]  color;
  logic signed [PH_W-1:0] color_x, dev_sel, off_sel, bb_inc;

  assign color   = chan_dr ? $signed(dr_i) : $signed(db_i);
  assign color_x = {{(PH_W-C_W){color[C_W-1]}}, color};
  assign dev_sel = chan_dr ? DR_DEV : DB_DEV;
  assign off_sel = chan_dr ? DR_OFF : DB_OFF;
  assign bb_inc  = off_sel + dev_sel * color_x;

  // index 0: reference, index 1: baseband
  logic                   step   [2];
  logic signed [PH_W-1:0] inc    [2];
  logic [ANG_W-1:0]       ang    [2];
  logic signed [SIN_W-1:0] sin_v [2];
  logic signed [SIN_W-1:0] cos_v [2];

  assign step[0] = en_i;
  assign inc[0]  = REF_INC;
  assign step[1] = en_i & active_i;
  assign inc[1]  = bb_inc;

  for (genvar k = 0; k < 2; k++) begin : g_osc
    secam_phase_acc #(.PH_W(PH_W), .ANG_W(ANG_W)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(step[k]),
      .inc_i (inc[k]),
      .ang_o (ang[k])
    );
    secam_sine #(.ANG_W(ANG_W)) u_sine (
      .ang_i(ang[k]),
      .sin_o(sin_v[k]),
      .cos_o(cos_v[k])
    );
  end

  logic [ANG_W-1:0] ref_ang, bb_ang;
  assign ref_ang = ang[0];
  assign bb_ang  = ang[1];

  // up-mix: sin(ref + bb) by the angle-sum identity
  logic signed [MIX_W-1:0] mix;
  logic signed [SCL_W-1:0] scaled, car, total;
  logic [Y_W-1:0]          sat;

  always_comb begin
    mix    = cos_v[0] * sin_v[1] + sin_v[0] * cos_v[1];
    scaled = mix * $signed({1'b0, gain_i});
    car    = scaled >>> SHIFT;
    total  = car + $signed({{(SCL_W-Y_W){1'b0}}, ysync_i});
    if (total < 0)          sat = '0;
    else if (total > Y_MAX) sat = Y_MAX[Y_W-1:0];
    else                    sat = total[Y_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cvbs_o <= '0;
    else if (en_i && active_i)    cvbs_o <= sat;
    else                          cvbs_o <= ysync_i;
  end

endmodule

// File: rtl/secam_fm_chk.sv
module secam_fm_chk #(
  parameter int ANG_W = 10,
  parameter int Y_W   = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             frame_i,
  input logic             line_i,
  input logic             active_i,
  input logic [Y_W-1:0]   ysync_i,
  input logic [Y_W-1:0]   cvbs_o,
  input logic             chan_dr,
  input logic [ANG_W-1:0] ref_ang,
  input logic [ANG_W-1:0] bb_ang
);

  a_r2_frame_db: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && frame_i |=> !chan_dr);

  a_r2_line_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && line_i && !frame_i |=> chan_dr != $past(chan_dr));

  a_r3_ref_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ref_ang));

  a_r4_bb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(bb_ang));

  a_r7_blank_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !active_i |=> cvbs_o == $past(ysync_i));

  a_r8_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cvbs_o == $past(ysync_i));

  a_r8_state_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(chan_dr) && $stable(bb_ang));

endmodule

bind secam_fm_gen secam_fm_chk #(.ANG_W(ANG_W), .Y_W(Y_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .frame_i (frame_i),
  .line_i  (line_i),
  .active_i(active_i),
  .ysync_i (ysync_i),
  .cvbs_o  (cvbs_o),
  .chan_dr (chan_dr),
  .ref_ang (ref_ang),
  .bb_ang  (bb_ang)
);

// File: tb/secam_fm_gen_tb.sv
module secam_fm_gen_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, frame_i = 1'b0, line_i = 1'b0, active_i = 1'b0;
  logic [9:0] db_i = '0, dr_i = '0, ysync_i = '0, cvbs_o;
  logic [7:0] gain_i = '0;

  always #10 clk_i = ~clk_i;

  secam_fm_gen u_dut (
    .clk_i, .rst_ni, .en_i, .frame_i, .line_i, .active_i,
    .db_i, .dr_i, .gain_i, .ysync_i, .cvbs_o
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam longint MASK = 64'h0000_0000_FFFF_FFFF;
  longint ref_inc, off_db, off_dr, dev_db, dev_dr;
  longint m_ref = 0, m_bb = 0;
  bit     m_dr = 1'b0;

  function automatic longint rinc(real hz, int frac);
    real x;
    x = hz * 4294967296.0 / 27.0e6 / (2.0 ** frac);
    return longint'($floor(x + 0.5));
  endfunction

  function automatic int psin(int a);
    int h, v;
    a = a % 1024;
    h = a % 512;
    v = (h * (512 - h)) / 512;
    return (a >= 512) ? -v : v;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: cvbs_o=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit en, bit fs, bit ls, bit act, int db, int dr,
                      int g, int y, string tag);
    int exp, pr, pb, mix, car, s, col;
    string t;
    en_i = en; frame_i = fs; line_i = ls; active_i = act;
    db_i = db[9:0]; dr_i = dr[9:0]; gain_i = g[7:0]; ysync_i = y[9:0];
    t = tag;
    if (!en) begin
      exp = y; t = "R8";
    end else begin
      if (act) begin
        pr  = int'(m_ref >> 22);
        pb  = int'(m_bb >> 22);
        mix = psin(pr + 256) * psin(pb) + psin(pr) * psin(pb + 256);
        car = (mix * g) >>> 15;
        s   = y + car;
        if (s > 1023)   begin exp = 1023; t = "R9"; end
        else if (s < 0) begin exp = 0;    t = "R9"; end
        else            exp = s;
        col  = m_dr ? dr : db;
        m_bb = (m_bb + (m_dr ? off_dr : off_db) + longint'(col) * (m_dr ? dev_dr : dev_db)) & MASK;
      end else begin
        exp = y; t = "R7";
      end
      m_ref = (m_ref + ref_inc) & MASK;
      if (fs)      m_dr = 1'b0;
      else if (ls) m_dr = ~m_dr;
    end
    @(posedge clk_i);
    #3;
    check(t, int'(cvbs_o), exp);
    @(negedge clk_i);
  endtask

  function automatic int pat_val(int pat, int i);
    case (pat)
      0: return 0;
      1: return 256;
      2: return i * 12 - 480;
      3: return $urandom_range(1022) - 511;
      default: return ((i / 10) % 2) ? -511 : 511;
    endcase
  endfunction

  task automatic run_line(bit fs, int g, int y, int pat, string tag);
    int v;
    step(1, fs, 1, 0, 0, 0, g, 64, tag);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 3, -3, g, 60 + i, tag);
    for (int i = 0; i < 80; i++) begin
      v = pat_val(pat, i);
      step(1, 0, 0, 1, v, 7 - v / 2, g, y + (i % 5), tag);
    end
  endtask

  initial begin
    ref_inc = rinc(4.286e6, 0);
    off_db  = rinc(4.25e6 - 4.286e6, 0);
    off_dr  = rinc(4.40625e6 - 4.286e6, 0);
    dev_db  = rinc(230.0e3, 8);
    dev_dr  = rinc(280.0e3, 8);
    repeat (4) @(negedge clk_i);
    check("R1", int'(cvbs_o), 0);
    ysync_i = 10'd77; en_i = 1'b1;
    @(negedge clk_i);
    check("R1", int'(cvbs_o), 0);
    en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_line(1, 128, 300, 0, "R6");
    run_line(0, 128, 300, 0, "R6");
    run_line(0, 200, 500, 1, "R4");
    run_line(0, 200, 500, 1, "R4");
    run_line(0, 180, 512, 2, "R3/R5");
    run_line(0, 180, 512, 3, "R2");
    for (int i = 0; i < 40; i++)
      step(0, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
           $urandom_range(1022) - 511, $urandom_range(1022) - 511,
           $urandom_range(255), $urandom_range(1023), "R8");
    run_line(0, 180, 512, 3, "R2");
    run_line(0, 255, 1000, 4, "R9");
    run_line(0, 255, 8, 4, "R9");
    run_line(1, 100, 400, 3, "R2");
    run_line(0, 100, 400, 2, "R2");
    run_line(0, 90, 450, 1, "R6");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: finished=%0d expected %0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule